// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the execute stage of a 32-bit processor core and decides when normal flow gives way to an exception handler. Seven request lines arrive from across the core: power-on restart, illegal opcode, software trap, instruction-fetch fault, data-access fault, normal interrupt and fast interrupt. The block picks one of them. It then drives a fixed two-cycle entry sequence that writes the banked saved-status and link registers, loads the new status word and sends the program counter to the handler's vector.

When a handler finishes, the core raises a return request together with the kind of exception being left, the banked link value and the banked saved status. The block then loads the program counter with the link value less a per-kind adjustment. It restores the status word from the saved copy unless the core is running in one of the two modes that have no saved copy. Every redirect of the program counter comes with a single-cycle flush pulse for the pipeline.

The status word keeps the mode in bits [4:0], the instruction-width flag in bit 5, the fast-interrupt mask in bit 6, the normal-interrupt mask in bit 7 and the condition flags above that. Neighbouring logic decodes these positions.

Top module: `trap_sequencer`

## Requirements
- R1: Granting priority, from highest to lowest, is restart, data-access fault, fast interrupt, normal interrupt, instruction-fetch fault, illegal opcode, software trap. Kind codes are restart 0, illegal opcode 1, software trap 2, fetch fault 3, data fault 4, normal interrupt 6 and fast interrupt 7. Code 5 is reserved.
- R2: A restart request is granted whether or not `instrDone` is high. Every other request is granted only in a cycle with `instrDone` high.
- R3: The normal-interrupt request has no effect while `curStatus[7]` is 1. The fast-interrupt request has no effect while `curStatus[6]` is 1.
- R4: The vector loaded on entry is `VECTOR_BASE + 4*kind`, which gives 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C with the default base.
- R5: In the first cycle after a grant, `savedWe` and `linkWe` are 1. In that cycle `savedOut` equals the status sampled at the grant, and `linkOut` equals `instrAddr` plus 4 for illegal opcode, software trap and fetch fault, or plus 8 for both interrupts and data fault. A restart grant writes neither register.
- R6: In the second cycle after a grant, `statusWe`, `pcWe` and `flush` are 1 for exactly one cycle. `newStatus` keeps bits [31:8], sets bit 7, clears bit 5, loads the target mode, and sets bit 6 only for restart and fast interrupt (otherwise bit 6 keeps its old value).
- R7: The target modes are 10011 (supervisor) for restart and software trap, 11011 for illegal opcode, 10111 for both faults, 10010 for the normal interrupt and 10001 for the fast interrupt. `bankMode` shows the target mode in both entry cycles.
- R8: One cycle after a return request, `pcWe` and `flush` pulse once. `pcOut` is `linkIn` for illegal opcode, software trap and the reserved codes 0 and 5. It is `linkIn - 4` for both interrupts and fetch fault, and `linkIn - 8` for data fault. `statusWe` is 1 with `newStatus` equal to `savedIn`.
- R9: A return requested while `curStatus[4:0]` is 10000 (user) or 11111 (system) loads the program counter but leaves `statusWe` at 0.
- R10: Requests that arrive while an entry or return sequence is running have no effect.
- R11: If an exception is granted in the same cycle as a return request, the entry sequence runs and the return request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| reqReset | input | 1 | Restart exception request |
| reqUndef | input | 1 | Illegal-opcode request |
| reqSwi | input | 1 | Software-trap request |
| reqPabt | input | 1 | Instruction-fetch fault request |
| reqDabt | input | 1 | Data-access fault request |
| reqIrq | input | 1 | Normal interrupt request |
| reqFiq | input | 1 | Fast interrupt request |
| instrDone | input | 1 | Current instruction completes this cycle |
| curStatus | input | STATUS_W | Current status word |
| instrAddr | input | ADDR_W | Address of the instruction at the boundary |
| retReq | input | 1 | Handler return request |
| retKind | input | 3 | Kind code of the exception being left |
| linkIn | input | ADDR_W | Banked link value for the return |
| savedIn | input | STATUS_W | Banked saved status for the return |
| savedWe | output | 1 | Write strobe for the saved status of `bankMode` |
| savedOut | output | STATUS_W | Status value to save |
| linkWe | output | 1 | Write strobe for the link register of `bankMode` |
| linkOut | output | ADDR_W | Return link value to store |
| bankMode | output | 5 | Mode whose banked registers are written |
| statusWe | output | 1 | Write strobe for the current status word |
| newStatus | output | STATUS_W | Status value to load |
| pcWe | output | 1 | Program counter load strobe |
| pcOut | output | ADDR_W | Program counter value to load |
| flush | output | 1 | One-cycle pipeline flush |

## Verification
The hardest case to reach is a request that arrives while a sequence is already running. The line is seen only at the grant point, so a request raised in the middle of an entry must not leave any trace once that entry ends. The bench raises a fast interrupt in the first entry cycle and drops it before the sequencer returns to idle, then checks that no second save appears. The priority checks drive several request lines in one cycle and read the winner from the mode and the vector. The masking and boundary checks drive an otherwise eligible request and check that every write strobe stays low for two cycles.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    KIND_RESET = 3'd0,
    KIND_UNDEF = 3'd1,
    KIND_SWI   = 3'd2,
    KIND_PABT  = 3'd3,
    KIND_DABT  = 3'd4,
    KIND_RSVD  = 3'd5,
    KIND_IRQ   = 3'd6,
    KIND_FIQ   = 3'd7
  } trapKind_e;

  // Mode field values (decoded by neighbouring logic)
  localparam logic [4:0] MODE_USER = 5'b10000;
  localparam logic [4:0] MODE_FIQ  = 5'b10001;
  localparam logic [4:0] MODE_IRQ  = 5'b10010;
  localparam logic [4:0] MODE_SVC  = 5'b10011;
  localparam logic [4:0] MODE_ABT  = 5'b10111;
  localparam logic [4:0] MODE_UND  = 5'b11011;
  localparam logic [4:0] MODE_SYS  = 5'b11111;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchEntry;
    logic latchRet;
    logic emitSave;
    logic emitLoad;
    logic emitRet;
  } trapStrobe_t;

  function automatic logic [4:0] targetMode(input trapKind_e kind);
    case (kind)
      KIND_RESET, KIND_SWI: return MODE_SVC;
      KIND_UNDEF:           return MODE_UND;
      KIND_PABT, KIND_DABT: return MODE_ABT;
      KIND_IRQ:             return MODE_IRQ;
      KIND_FIQ:             return MODE_FIQ;
      default:              return MODE_SVC;
    endcase
  endfunction

  // Bytes added to the boundary address to form the stored link
  function automatic int unsigned linkStep(input trapKind_e kind);
    case (kind)
      KIND_IRQ, KIND_FIQ, KIND_DABT: return 8;
      default:                       return 4;
    endcase
  endfunction

  // Bytes subtracted from the link on return
  function automatic int unsigned retAdjust(input trapKind_e kind);
    case (kind)
      KIND_IRQ, KIND_FIQ, KIND_PABT: return 4;
      KIND_DABT:                     return 8;
      default:                       return 0;
    endcase
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqReset,
  input  logic      reqUndef,
  input  logic      reqSwi,
  input  logic      reqPabt,
  input  logic      reqDabt,
  input  logic      reqIrq,
  input  logic      reqFiq,
  input  logic      instrDone,
  input  logic      maskI,
  input  logic      maskF,
  output logic      grantValid,
  output trapKind_e grantKind
);

  localparam int KIND_N = 8;
  localparam int PRIO_N = 7;
  // Highest priority first
  localparam logic [2:0] PRIO [PRIO_N] = '{3'd0, 3'd4, 3'd7, 3'd6, 3'd3, 3'd1, 3'd2};

  logic [KIND_N-1:0] eligible;

  always_comb begin
    eligible = '0;
    eligible[KIND_RESET] = reqReset;
    eligible[KIND_UNDEF] = reqUndef && instrDone;
    eligible[KIND_SWI]   = reqSwi   && instrDone;
    eligible[KIND_PABT]  = reqPabt  && instrDone;
    eligible[KIND_DABT]  = reqDabt  && instrDone;
    eligible[KIND_IRQ]   = reqIrq   && instrDone && !maskI;
    eligible[KIND_FIQ]   = reqFiq   && instrDone && !maskF;
  end

  always_comb begin
    grantValid = 1'b0;
    grantKind  = KIND_RESET;
    for (int i = PRIO_N - 1; i >= 0; i--) begin
      if (eligible[PRIO[i]]) begin
        grantValid = 1'b1;
        grantKind  = trapKind_e'(PRIO[i]);
      end
    end
  end

  assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReset |-> (grantValid && grantKind == KIND_RESET));

  assert_done_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !reqReset) |-> instrDone);

  assert_irq_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantKind == KIND_IRQ) |-> !maskI);

  assert_fiq_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantKind == KIND_FIQ) |-> !maskF);

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grantValid,
  input  logic        retReq,
  output trapStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD, ST_RET} seqState_e;

  seqState_e state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    strobe.emitSave   = (state == ST_SAVE);
    strobe.emitLoad   = (state == ST_LOAD);
    strobe.emitRet    = (state == ST_RET);
    case (state)
      ST_IDLE: begin
        if (grantValid) begin
          strobe.latchEntry = 1'b1;
          stateNext         = ST_SAVE;
        end else if (retReq) begin
          strobe.latchRet = 1'b1;
          stateNext       = ST_RET;
        end
      end
      ST_SAVE: stateNext = ST_LOAD;
      ST_LOAD: stateNext = ST_IDLE;
      ST_RET:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_save_then_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitSave |=> strobe.emitLoad);

  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitLoad || strobe.emitRet) |=> !(strobe.emitLoad || strobe.emitRet));

  assert_busy_no_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitSave || strobe.emitLoad || strobe.emitRet) |-> !(strobe.latchEntry || strobe.latchRet));

  assert_entry_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && retReq && !(strobe.emitSave || strobe.emitLoad || strobe.emitRet)) |=> strobe.emitSave);

endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                STATUS_W    = 32,
  parameter logic [ADDR_W-1:0] VECTOR_BASE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  trapStrobe_t         strobe,
  input  trapKind_e           grantKind,
  input  logic [STATUS_W-1:0] curStatus,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic [2:0]          retKind,
  input  logic [ADDR_W-1:0]   linkIn,
  input  logic [STATUS_W-1:0] savedIn,
  output logic                savedWe,
  output logic [STATUS_W-1:0] savedOut,
  output logic                linkWe,
  output logic [ADDR_W-1:0]   linkOut,
  output logic [4:0]          bankMode,
  output logic                statusWe,
  output logic [STATUS_W-1:0] newStatus,
  output logic                pcWe,
  output logic [ADDR_W-1:0]   pcOut,
  output logic                flush
);

  localparam int VEC_PAD = ADDR_W - 5;

  trapKind_e           kindQ;
  logic [STATUS_W-1:0] statusQ;
  logic [ADDR_W-1:0]   addrQ;
  trapKind_e           retKindQ;
  logic [ADDR_W-1:0]   linkQ;
  logic [STATUS_W-1:0] savedQ;
  logic                retPrivQ;

  logic [STATUS_W-1:0] entryStatus;
  logic [ADDR_W-1:0]   vectorAddr;
  logic [ADDR_W-1:0]   returnAddr;
  logic                curPriv;

  assign curPriv = (curStatus[4:0] != MODE_USER) && (curStatus[4:0] != MODE_SYS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ    <= KIND_RESET;
      statusQ  <= '0;
      addrQ    <= '0;
      retKindQ <= KIND_RESET;
      linkQ    <= '0;
      savedQ   <= '0;
      retPrivQ <= 1'b0;
    end else begin
      if (strobe.latchEntry) begin
        kindQ   <= grantKind;
        statusQ <= curStatus;
        addrQ   <= instrAddr;
      end
      if (strobe.latchRet) begin
        retKindQ <= trapKind_e'(retKind);
        linkQ    <= linkIn;
        savedQ   <= savedIn;
        retPrivQ <= curPriv;
      end
    end
  end

  always_comb begin
    entryStatus        = statusQ;
    entryStatus[BIT_T] = 1'b0;
    entryStatus[BIT_I] = 1'b1;
    if (kindQ == KIND_RESET || kindQ == KIND_FIQ) entryStatus[BIT_F] = 1'b1;
    entryStatus[4:0]   = targetMode(kindQ);
  end

  assign vectorAddr = VECTOR_BASE + {{VEC_PAD{1'b0}}, kindQ, 2'b00};
  assign returnAddr = linkQ - ADDR_W'(retAdjust(retKindQ));

  assign savedWe   = strobe.emitSave && (kindQ != KIND_RESET);
  assign linkWe    = strobe.emitSave && (kindQ != KIND_RESET);
  assign savedOut  = statusQ;
  assign linkOut   = addrQ + ADDR_W'(linkStep(kindQ));
  assign bankMode  = (strobe.emitSave || strobe.emitLoad) ? targetMode(kindQ) : 5'd0;
  assign statusWe  = strobe.emitLoad || (strobe.emitRet && retPrivQ);
  assign newStatus = strobe.emitRet ? savedQ : entryStatus;
  assign pcWe      = strobe.emitLoad || strobe.emitRet;
  assign pcOut     = strobe.emitRet ? returnAddr : vectorAddr;
  assign flush     = strobe.emitLoad || strobe.emitRet;

  assert_flags_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitLoad |-> (newStatus[STATUS_W-1:8] == $past(savedOut[STATUS_W-1:8])));

  assert_user_no_restore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitRet && !retPrivQ) |-> !statusWe);

  assert_vector_in_table_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitLoad |-> ((pcOut - VECTOR_BASE) < ADDR_W'(32)));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                STATUS_W    = 32,
  parameter logic [ADDR_W-1:0] VECTOR_BASE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqReset,
  input  logic                reqUndef,
  input  logic                reqSwi,
  input  logic                reqPabt,
  input  logic                reqDabt,
  input  logic                reqIrq,
  input  logic                reqFiq,
  input  logic                instrDone,
  input  logic [STATUS_W-1:0] curStatus,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic                retReq,
  input  logic [2:0]          retKind,
  input  logic [ADDR_W-1:0]   linkIn,
  input  logic [STATUS_W-1:0] savedIn,
  output logic                savedWe,
  output logic [STATUS_W-1:0] savedOut,
  output logic                linkWe,
  output logic [ADDR_W-1:0]   linkOut,
  output logic [4:0]          bankMode,
  output logic                statusWe,
  output logic [STATUS_W-1:0] newStatus,
  output logic                pcWe,
  output logic [ADDR_W-1:0]   pcOut,
  output logic                flush
);

  logic        grantValid;
  trapKind_e   grantKind;
  trapStrobe_t strobe;

  trap_arbiter u_arbiter (
    .clk        (clk),
    .rstN       (rstN),
    .reqReset   (reqReset),
    .reqUndef   (reqUndef),
    .reqSwi     (reqSwi),
    .reqPabt    (reqPabt),
    .reqDabt    (reqDabt),
    .reqIrq     (reqIrq),
    .reqFiq     (reqFiq),
    .instrDone  (instrDone),
    .maskI      (curStatus[BIT_I]),
    .maskF      (curStatus[BIT_F]),
    .grantValid (grantValid),
    .grantKind  (grantKind)
  );

  trap_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .grantValid (grantValid),
    .retReq     (retReq),
    .strobe     (strobe)
  );

  trap_dpath #(
    .ADDR_W      (ADDR_W),
    .STATUS_W    (STATUS_W),
    .VECTOR_BASE (VECTOR_BASE)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .grantKind  (grantKind),
    .curStatus  (curStatus),
    .instrAddr  (instrAddr),
    .retKind    (retKind),
    .linkIn     (linkIn),
    .savedIn    (savedIn),
    .savedWe    (savedWe),
    .savedOut   (savedOut),
    .linkWe     (linkWe),
    .linkOut    (linkOut),
    .bankMode   (bankMode),
    .statusWe   (statusWe),
    .newStatus  (newStatus),
    .pcWe       (pcWe),
    .pcOut      (pcOut),
    .flush      (flush)
  );

endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqReset, reqUndef, reqSwi, reqPabt, reqDabt, reqIrq, reqFiq;
  logic        instrDone;
  logic [31:0] curStatus, instrAddr, linkIn, savedIn;
  logic        retReq;
  logic [2:0]  retKind;
  logic        savedWe, linkWe, statusWe, pcWe, flush;
  logic [31:0] savedOut, linkOut, newStatus, pcOut;
  logic [4:0]  bankMode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer u_dut (
    .clk(clk), .rstN(rstN),
    .reqReset(reqReset), .reqUndef(reqUndef), .reqSwi(reqSwi), .reqPabt(reqPabt),
    .reqDabt(reqDabt), .reqIrq(reqIrq), .reqFiq(reqFiq), .instrDone(instrDone),
    .curStatus(curStatus), .instrAddr(instrAddr), .retReq(retReq), .retKind(retKind),
    .linkIn(linkIn), .savedIn(savedIn),
    .savedWe(savedWe), .savedOut(savedOut), .linkWe(linkWe), .linkOut(linkOut),
    .bankMode(bankMode), .statusWe(statusWe), .newStatus(newStatus),
    .pcWe(pcWe), .pcOut(pcOut), .flush(flush)
  );

  // Expected values taken from the requirements
  function automatic logic [4:0] expMode(input int kind);
    case (kind)
      0, 2: return 5'b10011;
      1:    return 5'b11011;
      3, 4: return 5'b10111;
      6:    return 5'b10010;
      7:    return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] expLinkStep(input int kind);
    return (kind == 4 || kind == 6 || kind == 7) ? 32'd8 : 32'd4;
  endfunction

  function automatic logic [31:0] expRetAdj(input int kind);
    if (kind == 3 || kind == 6 || kind == 7) return 32'd4;
    if (kind == 4) return 32'd8;
    return 32'd0;
  endfunction

  function automatic logic [31:0] expEntryStatus(input logic [31:0] st, input int kind);
    logic [31:0] r;
    r = st;
    r[7] = 1'b1;
    r[5] = 1'b0;
    if (kind == 0 || kind == 7) r[6] = 1'b1;
    r[4:0] = expMode(kind);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clearInputs();
    {reqReset, reqUndef, reqSwi, reqPabt, reqDabt, reqIrq, reqFiq} = '0;
    instrDone = 1'b0;
    retReq    = 1'b0;
    retKind   = 3'd0;
    linkIn    = '0;
    savedIn   = '0;
  endtask

  // reqs bit n drives the request whose kind code is n
  task automatic driveReqs(input logic [7:0] reqs);
    reqReset = reqs[0]; reqUndef = reqs[1]; reqSwi = reqs[2]; reqPabt = reqs[3];
    reqDabt  = reqs[4]; reqIrq   = reqs[6]; reqFiq = reqs[7];
  endtask

  task automatic entryCase(input string tag, input logic [7:0] reqs, input logic done,
                           input logic [31:0] st, input logic [31:0] addr, input int kind);
    @(negedge clk);
    driveReqs(reqs); instrDone = done; curStatus = st; instrAddr = addr;
    @(negedge clk);
    clearInputs();
    curStatus = 32'h0000_00D3;
    chk({tag, " R5 savedWe"}, {31'd0, savedWe}, (kind != 0) ? 32'd1 : 32'd0);
    chk({tag, " R5 linkWe"},  {31'd0, linkWe},  (kind != 0) ? 32'd1 : 32'd0);
    if (kind != 0) begin
      chk({tag, " R5 savedOut"}, savedOut, st);
      chk({tag, " R5 linkOut"},  linkOut, addr + expLinkStep(kind));
    end
    chk({tag, " R7 bankMode"}, {27'd0, bankMode}, {27'd0, expMode(kind)});
    chk({tag, " R6 no early pc"}, {31'd0, pcWe}, 32'd0);
    @(negedge clk);
    chk({tag, " R6 statusWe"}, {31'd0, statusWe}, 32'd1);
    chk({tag, " R6 newStatus"}, newStatus, expEntryStatus(st, kind));
    chk({tag, " R4 pcWe"}, {31'd0, pcWe}, 32'd1);
    chk({tag, " R4 vector"}, pcOut, 32'(kind * 4));
    chk({tag, " R6 flush"}, {31'd0, flush}, 32'd1);
    @(negedge clk);
    chk({tag, " R6 flush ends"}, {29'd0, flush, pcWe, statusWe}, 32'd0);
  endtask

  task automatic noEntryCase(input string tag, input logic [7:0] reqs, input logic done,
                             input logic [31:0] st);
    @(negedge clk);
    driveReqs(reqs); instrDone = done; curStatus = st; instrAddr = 32'h100;
    @(negedge clk);
    chk({tag, " no save"}, {30'd0, savedWe, linkWe}, 32'd0);
    @(negedge clk);
    chk({tag, " no load"}, {29'd0, flush, pcWe, statusWe}, 32'd0);
    clearInputs();
    @(negedge clk);
  endtask

  task automatic retCase(input string tag, input int kind, input logic [31:0] link,
                         input logic [31:0] saved, input logic [31:0] cur, input logic restore);
    @(negedge clk);
    retReq = 1'b1; retKind = 3'(kind); linkIn = link; savedIn = saved; curStatus = cur;
    @(negedge clk);
    clearInputs();
    chk({tag, " R8 pcWe"}, {31'd0, pcWe}, 32'd1);
    chk({tag, " R8 pcOut"}, pcOut, link - expRetAdj(kind));
    chk({tag, " R8 flush"}, {31'd0, flush}, 32'd1);
    chk({tag, " R9 statusWe"}, {31'd0, statusWe}, {31'd0, restore});
    if (restore) chk({tag, " R8 newStatus"}, newStatus, saved);
    chk({tag, " R8 no bank write"}, {30'd0, savedWe, linkWe}, 32'd0);
    @(negedge clk);
    chk({tag, " R8 flush ends"}, {30'd0, flush, pcWe}, 32'd0);
  endtask

  task automatic busyCase();
    @(negedge clk);
    reqSwi = 1'b1; instrDone = 1'b1; curStatus = 32'h0000_0010; instrAddr = 32'h200;
    @(negedge clk);
    clearInputs();
    reqFiq = 1'b1; instrDone = 1'b1; curStatus = 32'h0000_0010;
    @(negedge clk);
    chk("R10 load continues", pcOut, 32'h08);
    clearInputs();
    @(negedge clk);
    chk("R10 no second save", {30'd0, savedWe, linkWe}, 32'd0);
    @(negedge clk);
    chk("R10 no second load", {30'd0, pcWe, flush}, 32'd0);
  endtask

  task automatic collideCase();
    @(negedge clk);
    reqIrq = 1'b1; instrDone = 1'b1; curStatus = 32'h0000_0010; instrAddr = 32'h300;
    retReq = 1'b1; retKind = 3'd2; linkIn = 32'h444; savedIn = 32'h10;
    @(negedge clk);
    clearInputs();
    chk("R11 entry save", {31'd0, savedWe}, 32'd1);
    chk("R11 return dropped", {31'd0, pcWe}, 32'd0);
    @(negedge clk);
    chk("R11 vector", pcOut, 32'h18);
    @(negedge clk);
    chk("R11 no late return", {31'd0, pcWe}, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (R1 to R11 incomplete)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    clearInputs();
    curStatus = 32'h0000_0010;
    instrAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset state strobes",
        {26'd0, savedWe, linkWe, statusWe, pcWe, flush, 1'b0}, 32'd0);

    // R7, R4, R5, R6: each kind alone
    entryCase("undef",  8'h02, 1'b1, 32'hA000_0010, 32'h0000_1000, 1);
    entryCase("swi",    8'h04, 1'b1, 32'h4000_0030, 32'h0000_2004, 2);
    entryCase("pabt",   8'h08, 1'b1, 32'h0000_0013, 32'h0000_3008, 3);
    entryCase("dabt",   8'h10, 1'b1, 32'h2000_0012, 32'h0000_400C, 4);
    entryCase("irq",    8'h40, 1'b1, 32'h9000_0050, 32'h0000_5010, 6);
    entryCase("fiq",    8'h80, 1'b1, 32'hF000_0010, 32'h0000_6014, 7);
    entryCase("reset",  8'h01, 1'b1, 32'h0000_0010, 32'h0000_7000, 0);

    // R1 priority
    entryCase("R1 all",        8'hDF, 1'b1, 32'h0000_0010, 32'h80, 0);
    entryCase("R1 dabt>fiq",   8'hDE, 1'b1, 32'h0000_0010, 32'h84, 4);
    entryCase("R1 fiq>irq",    8'hCE, 1'b1, 32'h0000_0010, 32'h88, 7);
    entryCase("R1 irq>pabt",   8'h4E, 1'b1, 32'h0000_0010, 32'h8C, 6);
    entryCase("R1 pabt>undef", 8'h0E, 1'b1, 32'h0000_0010, 32'h90, 3);
    entryCase("R1 undef>swi",  8'h06, 1'b1, 32'h0000_0010, 32'h94, 1);

    // R2 instruction boundary
    noEntryCase("R2 undef waits", 8'h02, 1'b0, 32'h0000_0010);
    noEntryCase("R2 irq waits",   8'h40, 1'b0, 32'h0000_0010);
    entryCase("R2 reset no boundary", 8'h01, 1'b0, 32'h0000_0010, 32'hA0, 0);

    // R3 masking
    noEntryCase("R3 irq masked", 8'h40, 1'b1, 32'h0000_0090);
    noEntryCase("R3 fiq masked", 8'h80, 1'b1, 32'h0000_0050);
    entryCase("R3 fiq under I", 8'hC0, 1'b1, 32'h0000_0090, 32'hB0, 7);
    entryCase("R3 irq under F", 8'hC0, 1'b1, 32'h0000_0050, 32'hB4, 6);

    // R8, R9 returns
    retCase("ret swi",   2, 32'h0000_2008, 32'h6000_0010, 32'h0000_0093, 1'b1);
    retCase("ret undef", 1, 32'h0000_1004, 32'h0000_0010, 32'h0000_009B, 1'b1);
    retCase("ret irq",   6, 32'h0000_5018, 32'h8000_0010, 32'h0000_0092, 1'b1);
    retCase("ret fiq",   7, 32'h0000_601C, 32'h0000_0013, 32'h0000_00D1, 1'b1);
    retCase("ret pabt",  3, 32'h0000_300C, 32'h0000_0010, 32'h0000_0097, 1'b1);
    retCase("ret dabt",  4, 32'h0000_4014, 32'h0000_001F, 32'h0000_0097, 1'b1);
    retCase("ret rsvd",  5, 32'h0000_0040, 32'h0000_0010, 32'h0000_0093, 1'b1);
    retCase("R9 user",   6, 32'h0000_0050, 32'h0000_0012, 32'h0000_0010, 1'b0);
    retCase("R9 system", 4, 32'h0000_0060, 32'h0000_0013, 32'h0000_001F, 1'b0);

    busyCase();
    collideCase();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule